// File: doc/BRIEF.md
# UART Transmitter with Buffer-Empty and Transmit-Complete Flags

This block sends bytes on a serial line using 8N1 framing. Each frame has a low start bit, eight data bits sent least significant bit first, and a high stop bit. The line idles high. A one-byte holding register sits in front of the shift register. A programmable divisor sets how many system clocks one bit lasts. Because of the holding register, software or a DMA engine can keep the line busy with no idle gap between frames.

Two sticky flags report progress. The buffer-empty flag rises when the shifter takes the held byte, which happens at the end of that byte's start bit. The DMA request output follows this flag. The transmit-complete flag rises at the end of every stop bit, including when another byte is already waiting. Loading the shifter never clears it. Software therefore detects the true end of a stream by clearing the flag after its last write and then waiting for two completions, ten bit-times apart.

The flags are cleared by a write-one-to-clear access or by a read of the interrupt vector. The vector read returns the highest-priority pending enabled flag and clears only that flag. A data write that arrives while the buffer is full is dropped and sets an overrun bit.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, tx_out is 1, dma_req is 1, irq is 0, and the status register (address 2) reads 1. The status bits are bit 0 buffer-empty, bit 1 transmit-complete and bit 2 overrun. With no interrupt enabled, the vector register (address 4) reads 0.
- R2: Every byte written to address 0 is sent once as a start bit (0), then its eight data bits least significant bit first, then a stop bit (1). Each of these bits lasts one bit period.
- R3: A data write clears the buffer-empty flag, and dma_req with it, at the clock edge that registers the write.
- R4: When the line is idle, the start bit appears on tx_out one clock after the write edge. Buffer-empty sets again one bit period after the start bit began, which is D+1 clocks after the write edge, where D is the bit period in clocks.
- R5: Transmit-complete sets at the edge that ends every stop bit, 10·D+1 clocks after a write that found the line idle. It also sets when a held byte starts its frame at that same edge, and that start does not clear it.
- R6: While streaming, a held byte starts its start bit at the edge that ends the previous stop bit. Buffer-empty then sets D clocks after that transmit-complete.
- R7: After the final byte of a stream is written, transmit-complete rises exactly twice if it is cleared after each rise. The two rises are 10·D clocks apart.
- R8: A data write while the holding register is full is dropped, so its byte is never sent, and it sets the overrun bit.
- R9: Writing address 2 clears each status bit whose data bit is 1. A flag that is set and cleared at the same edge stays set.
- R10: The interrupt enable register is address 3: bit 0 enables buffer-empty and bit 1 enables transmit-complete. Address 4 reads 2 for enabled buffer-empty, else 4 for enabled transmit-complete, else 0. That read clears only the flag it reports. irq is high while any enabled flag is set.
- R11: The divisor register is address 1 and reads back as written. A value N ≥ 1 gives a bit period of N clocks, and 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a vector read clears a flag) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high, 0 otherwise |
| tx_out | output | 1 | Serial transmit line |
| dma_req | output | 1 | Transfer request, follows buffer-empty |
| irq | output | 1 | High while any enabled flag is set |

## Verification
The assertions assume that the divisor register changes only while no frame is on the line. The bit counter's range check depends on this. The stimulus writes a new divisor only after the previous frame and its completion have been observed. The assertions also assume that each bus access is a single-cycle strobe. The bench drives every access for exactly one clock, half a cycle away from the sampling edge. It times the set-versus-clear collision deliberately so that the clear lands on the very edge where transmit-complete sets.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_VEC  = 3'd4;

  typedef enum logic [2:0] {
    VEC_NONE  = 3'd0,
    VEC_EMPTY = 3'd2,
    VEC_DONE  = 3'd4
  } vec_e;
endpackage

// File: rtl/uart_tx_baud.sv
`timescale 1ns/1ps
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] period;

  function automatic logic [DIV_W-1:0] bit_period(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  assign period = bit_period(divisor);
  assign tick   = run && (cnt == period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  p_cnt_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < period));
  p_cnt_parked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/uart_tx_shift.sv
`timescale 1ns/1ps
module uart_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              take,
  output logic              frame_end,
  output logic              wr_reject,
  output logic              tx_out
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

  logic              full;
  logic [DATA_W-1:0] hold;
  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;
  logic              launch;

  // Slot 0 is the start bit, slots 1..DATA_W carry data LSB first, the last is the stop bit.
  function automatic logic line_level(input logic [DATA_W-1:0] d, input logic [IDX_W-1:0] i);
    logic lvl;
    lvl = 1'b1;
    if (i == '0) lvl = 1'b0;
    for (int b = 0; b < DATA_W; b++)
      if (int'(i) == b + 1) lvl = d[b];
    return lvl;
  endfunction

  assign wr_reject = wr_data && full;
  assign take      = busy && tick && (idx == '0);
  assign frame_end = busy && tick && (idx == LAST);
  assign launch    = full && (!busy || frame_end);
  assign tx_out    = busy ? line_level(shreg, idx) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full  <= 1'b0;
      hold  <= '0;
      busy  <= 1'b0;
      idx   <= '0;
      shreg <= '0;
    end else begin
      if (wr_data && !full) begin
        full <= 1'b1;
        hold <= wdata;
      end else if (take) begin
        full <= 1'b0;
      end
      if (launch) begin
        busy  <= 1'b1;
        idx   <= '0;
        shreg <= hold;
      end else if (frame_end) begin
        busy <= 1'b0;
      end else if (busy && tick) begin
        idx <= idx + 1'b1;
      end
    end
  end

  p_take_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);
  p_bit_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(tx_out));
  p_stream_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && full) |=> (busy && (idx == '0) && !tx_out));
  p_idle_line_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !full) |=> tx_out);
endmodule

// File: rtl/uart_tx_regs.sv
`timescale 1ns/1ps
module uart_tx_regs
  import uart_tx_pkg::*;
#(
  parameter int              DIV_W     = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DIV_W-1:0]  bus_wdata,
  input  logic              take,
  input  logic              frame_end,
  input  logic              wr_reject,
  output logic [DIV_W-1:0]  bus_rdata,
  output logic [DIV_W-1:0]  divisor,
  output logic              data_wr,
  output logic              dma_req,
  output logic              irq
);
  logic       flag_empty, flag_done, flag_ovr;
  logic [1:0] ien;
  vec_e       vec_code;
  logic       vec_rd, stat_w1c;
  logic       clr_empty, clr_done, clr_ovr;

  assign data_wr  = bus_wr && (bus_addr == A_DATA);
  assign stat_w1c = bus_wr && (bus_addr == A_STAT);
  assign vec_rd   = bus_rd && (bus_addr == A_VEC);

  always_comb begin
    if (flag_empty && ien[0])     vec_code = VEC_EMPTY;
    else if (flag_done && ien[1]) vec_code = VEC_DONE;
    else                          vec_code = VEC_NONE;
  end

  assign clr_empty = data_wr || (stat_w1c && bus_wdata[0]) || (vec_rd && vec_code == VEC_EMPTY);
  assign clr_done  = (stat_w1c && bus_wdata[1]) || (vec_rd && vec_code == VEC_DONE);
  assign clr_ovr   = stat_w1c && bus_wdata[2];

  assign dma_req = flag_empty;
  assign irq     = (flag_empty && ien[0]) || (flag_done && ien[1]);

  // A set event outranks a clear on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_empty <= 1'b1;
      flag_done  <= 1'b0;
      flag_ovr   <= 1'b0;
      ien        <= '0;
      divisor    <= DIV_RESET;
    end else begin
      if (take)           flag_empty <= 1'b1;
      else if (clr_empty) flag_empty <= 1'b0;
      if (frame_end)      flag_done  <= 1'b1;
      else if (clr_done)  flag_done  <= 1'b0;
      if (wr_reject)      flag_ovr   <= 1'b1;
      else if (clr_ovr)   flag_ovr   <= 1'b0;
      if (bus_wr && bus_addr == A_IEN) ien     <= bus_wdata[1:0];
      if (bus_wr && bus_addr == A_DIV) divisor <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_DIV:   bus_rdata = divisor;
        A_STAT:  bus_rdata = DIV_W'({flag_ovr, flag_done, flag_empty});
        A_IEN:   bus_rdata = DIV_W'(ien);
        A_VEC:   bus_rdata = DIV_W'(vec_code);
        default: bus_rdata = '0;
      endcase
    end
  end

  p_done_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> flag_done);
  p_empty_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> flag_empty);
  p_write_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !take) |=> !flag_empty);
  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> flag_ovr);
  p_vec_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec_code == VEC_DONE && !frame_end) |=> !flag_done);
endmodule

// File: rtl/uart_tx_core.sv
`timescale 1ns/1ps
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int               DATA_W    = 8,
  parameter int               DIV_W     = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DIV_W-1:0]  bus_wdata,
  output logic [DIV_W-1:0]  bus_rdata,
  output logic              tx_out,
  output logic              dma_req,
  output logic              irq
);
  logic             tick, busy, take, frame_end, wr_reject, data_wr;
  logic [DIV_W-1:0] divisor;

  uart_tx_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .take(take),
    .frame_end(frame_end), .wr_reject(wr_reject), .bus_rdata(bus_rdata),
    .divisor(divisor), .data_wr(data_wr), .dma_req(dma_req), .irq(irq)
  );

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .divisor(divisor), .tick(tick)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_data(data_wr),
    .wdata(bus_wdata[DATA_W-1:0]), .busy(busy), .take(take),
    .frame_end(frame_end), .wr_reject(wr_reject), .tx_out(tx_out)
  );
endmodule

// File: tb/uart_tx_core_test.sv
`timescale 1ns/1ps
module uart_tx_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tx_out, dma_req, irq;

  int checks = 0, errors = 0;
  int cyc = 0;
  int cur_div = 16;
  logic [7:0] exp_q[$];
  int d_times[$], e_times[$];
  logic d_tx[$];
  bit rec = 0;
  logic prev_irq = 0, prev_dma = 0;

  uart_tx_core uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_out(tx_out), .dma_req(dma_req), .irq(irq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output int d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = int'(bus_rdata);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // Driver: every accepted byte is queued for the line monitor.
  task automatic send(input logic [7:0] b);
    bus_write(3'd0, {8'h00, b});
    exp_q.push_back(b);
  endtask

  // Monitor: decodes frames at bit resolution and pops the scoreboard.
  initial begin
    logic [9:0] bits;
    logic [7:0] exp;
    forever begin
      @(negedge clk);
      if (rst_n && tx_out === 1'b0) begin
        bits[0] = tx_out;
        for (int j = 1; j < 10; j++) begin
          repeat (cur_div) @(negedge clk);
          bits[j] = tx_out;
        end
        if (exp_q.size() == 0) begin
          chk("R2", "unexpected frame on line", int'(bits[8:1]), -1);
        end else begin
          exp = exp_q.pop_front();
          chk("R2", "frame data LSB first", int'(bits[8:1]), int'(exp));
          chk("R2", "stop bit level", int'(bits[9]), 1);
        end
      end
    end
  end

  // Event stamps for the streaming test.
  always @(negedge clk) begin
    if (rec && irq && !prev_irq) begin d_times.push_back(cyc); d_tx.push_back(tx_out); end
    if (rec && dma_req && !prev_dma) e_times.push_back(cyc);
    prev_irq <= irq;
    prev_dma <= dma_req;
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rd, d, n, wcyc, k;
    logic [7:0] stream [4];
    stream[0] = 8'h00; stream[1] = 8'hFF; stream[2] = 8'h5A; stream[3] = 8'hC3;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "tx idle", int'(tx_out), 1);
    chk("R1", "dma_req", int'(dma_req), 1);
    chk("R1", "irq", int'(irq), 0);
    bus_read(3'd2, rd); chk("R1", "status", rd, 1);
    bus_read(3'd4, rd); chk("R1", "vector none", rd, 0);

    // Single frame timing, D=4, done interrupt only
    d = 4; cur_div = d;
    bus_write(3'd1, 16'(d));
    bus_write(3'd3, 16'd2);
    send(8'hA5);
    chk("R3", "dma_req cleared by write", int'(dma_req), 0);
    chk("R4", "line still idle at write edge", int'(tx_out), 1);
    @(negedge clk);
    chk("R4", "start bit one clock after write", int'(tx_out), 0);
    repeat (d - 1) @(negedge clk);
    chk("R4", "empty not yet set", int'(dma_req), 0);
    @(negedge clk);
    chk("R4", "empty set after start bit", int'(dma_req), 1);
    repeat (9 * d - 1) @(negedge clk);
    chk("R5", "done not set before stop end", int'(irq), 0);
    bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 16'd2;
    @(negedge clk); bus_wr = 1'b0;
    chk("R9", "set wins over same-edge clear", int'(irq), 1);
    chk("R5", "line idle after stop", int'(tx_out), 1);
    bus_write(3'd2, 16'd2);
    chk("R9", "w1c clears done", int'(irq), 0);

    // Interrupt vector priority and clearing
    send(8'h3C);
    repeat (10 * d + 4) @(negedge clk);
    bus_write(3'd3, 16'd3);
    bus_read(3'd4, rd); chk("R10", "empty has priority", rd, 2);
    chk("R10", "vector read cleared empty", int'(dma_req), 0);
    bus_read(3'd4, rd); chk("R10", "done reported next", rd, 4);
    chk("R10", "irq low after both cleared", int'(irq), 0);
    bus_read(3'd4, rd); chk("R10", "nothing pending", rd, 0);
    send(8'h81);
    repeat (10 * d + 4) @(negedge clk);
    bus_write(3'd3, 16'd2);
    bus_read(3'd4, rd); chk("R10", "disabled empty skipped", rd, 4);
    chk("R10", "empty untouched by read", int'(dma_req), 1);
    bus_read(3'd2, rd); chk("R10", "status after vector read", rd, 1);

    // Overrun
    send(8'h11);
    bus_write(3'd0, 16'h0022);
    bus_read(3'd2, rd); chk("R8", "overrun set, dropped write", rd, 4);
    bus_write(3'd2, 16'd4);
    repeat (10 * d + 4) @(negedge clk);
    bus_read(3'd2, rd); chk("R8", "overrun cleared, frame done", rd, 3);
    bus_write(3'd2, 16'd2);

    // Streaming, D=6
    d = 6; cur_div = d;
    bus_write(3'd1, 16'(d));
    n = 0; wcyc = 0; rec = 1;
    for (int c = 0; c < 80 * d; c++) begin
      @(negedge clk);
      bus_wr = 1'b0;
      if (dma_req && n < 4) begin
        if (n == 0) wcyc = cyc;
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = {8'h00, stream[n]};
        exp_q.push_back(stream[n]);
        n++;
        if (n == 4) k = cyc;
      end else if (irq) begin
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 16'd2;
      end
    end
    @(negedge clk); bus_wr = 1'b0; rec = 0;
    chk("R6", "done events", d_times.size(), 4);
    chk("R6", "empty events", e_times.size(), 4);
    if (d_times.size() == 4 && e_times.size() == 4) begin
      chk("R4", "first empty", e_times[0], wcyc + 1 + d + 1);
      chk("R5", "first done", d_times[0], wcyc + 1 + 10 * d + 1);
      for (int i = 1; i < 4; i++) begin
        chk("R6", "done spacing", d_times[i] - d_times[i-1], 10 * d);
        chk("R6", "empty one bit after done", e_times[i] - d_times[i-1], d);
      end
      for (int i = 0; i < 3; i++)
        chk("R5", "next frame started at done", int'(d_tx[i]), 0);
      n = 0;
      foreach (d_times[i]) if (d_times[i] > k) n++;
      chk("R7", "done rises after last write", n, 2);
      chk("R7", "final pair spacing", d_times[3] - d_times[2], 10 * d);
    end

    // Divisor 0 acts as 1, then 7
    cur_div = 1;
    bus_write(3'd1, 16'd0);
    send(8'h96);
    chk("R3", "dma_req cleared", int'(dma_req), 0);
    @(negedge clk);
    chk("R11", "start bit at divisor 0", int'(tx_out), 0);
    @(negedge clk);
    chk("R11", "empty after one clock bit", int'(dma_req), 1);
    repeat (8) @(negedge clk);
    chk("R11", "done not yet", int'(irq), 0);
    @(negedge clk);
    chk("R11", "done after ten clocks", int'(irq), 1);
    bus_write(3'd2, 16'd2);
    d = 7; cur_div = d;
    bus_write(3'd1, 16'(d));
    bus_read(3'd1, rd); chk("R11", "divisor readback", rd, 7);
    send(8'hE7);
    repeat (10 * d) @(negedge clk);
    chk("R11", "done not yet at divisor 7", int'(irq), 0);
    @(negedge clk);
    chk("R11", "done at divisor 7", int'(irq), 1);
    bus_write(3'd2, 16'd2);
    repeat (20) @(negedge clk);
    chk("R2", "all queued bytes seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule